// File: doc/BRIEF.md
# ADC Output Formatting Stage

This block sits between a 12-bit converter and the data pins of a signal-processing front end. Each converter word can be recoded from straight binary to Gray code. The word is then either captured in an output register on the cycles chosen by a phase-select strobe, or passed straight to the bus with no register in the path. A separate control can disable the bus. Pad drivers use the output-enable to three-state the pins.

The three control inputs act independently: one picks the coding, one bypasses the output register, and one disables the bus. Gray conversion happens before the register, so the register always holds an already-coded word. The register keeps capturing while the bus is disabled, so the first cycle after re-enabling shows current data. The asynchronous active-low reset is released in step with the pixel clock and clears the register to zero.

Top module: `adc_out_stage`

## Requirements
- R1: After reset, with binary coding, latched mode and the bus enabled, the data bus reads 0 and the output-enable is 1.
- R2: In latched mode, the word at the data input on a rising clock edge where the phase-select strobe is high appears on the bus from that edge on (one cycle of latency).
- R3: In latched mode, a rising edge with the strobe low leaves the bus unchanged, whatever the data input does.
- R4: When the bypass control is 1, the bus follows the coded data input in the same cycle, with no clock edge needed.
- R5: When the Gray control is 1, the coded word is g = b XOR (b >> 1) (for example, 0x800 gives 0xC00 and 0xFFF gives 0x800). When it is 0, the word is passed unchanged as straight binary.
- R6: When the disable control is 1, the output-enable is 0 and the data bus is driven to all zeros.
- R7: The output register keeps capturing on strobe edges while the bus is disabled. In the first cycle after the disable control returns to 0, the bus shows the last word captured.
- R8: Coding is applied before the register. Changing the Gray control after a capture does not alter the latched word on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_word | input | 12 | Raw converter result, straight binary |
| phase_stb | input | 1 | Capture strobe for the programmed output phase |
| ctl_bypass | input | 1 | 1 = output register transparent |
| ctl_hiz | input | 1 | 1 = bus disabled (three-state request) |
| ctl_gray | input | 1 | 1 = Gray coding, 0 = straight binary |
| dout | output | 12 | Formatted data bus |
| dout_oe | output | 1 | Output-enable for the pad drivers |

## Verification
The assertions assume the three control bits are static configuration. Between strobes they change only at sampled clock boundaries, never partway through a cycle. The assertions also assume that a capture counts only once the internally synchronized reset has been released. The bench drives every input on the falling edge and keeps the controls steady around each capture edge. It waits several cycles after releasing reset before the first strobe, so every expected value rests on a capture edge that the stimulus defines cleanly.

// File: rtl/aos_pkg.sv
package aos_pkg;
  typedef struct packed {
    logic bypass;
    logic hiz;
    logic gray;
  } aos_ctl_t;
endpackage

// File: rtl/aos_rst_sync.sv
module aos_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/aos_gray_enc.sv
module aos_gray_enc #(
  parameter int DATA_W = 12
) (
  input  logic              gray_en,
  input  logic [DATA_W-1:0] bin_in,
  output logic [DATA_W-1:0] code_out
);
  logic [DATA_W-1:0] gray_w;

  assign gray_w[DATA_W-1] = bin_in[DATA_W-1];
  for (genvar i = 0; i < DATA_W-1; i++) begin : g_bit
    assign gray_w[i] = bin_in[i] ^ bin_in[i+1];
  end

  assign code_out = gray_en ? gray_w : bin_in;
endmodule

// File: rtl/aos_phase_latch.sv
module aos_phase_latch #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] q_out
);
  logic [DATA_W-1:0] held_q;
  logic [DATA_W-1:0] held_d;

  always_comb begin
    held_d = held_q;
    if (cap_en) held_d = d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign q_out = held_q;
endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage #(
  parameter int DATA_W     = 12,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] adc_word,
  input  logic              phase_stb,
  input  logic              ctl_bypass,
  input  logic              ctl_hiz,
  input  logic              ctl_gray,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  import aos_pkg::*;

  aos_ctl_t          ctl;
  logic              rst_sync_n;
  logic [DATA_W-1:0] coded;
  logic [DATA_W-1:0] latched;
  logic [DATA_W-1:0] selected;

  assign ctl = '{bypass: ctl_bypass, hiz: ctl_hiz, gray: ctl_gray};

  aos_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  aos_gray_enc #(.DATA_W(DATA_W)) u_enc (
    .gray_en  (ctl.gray),
    .bin_in   (adc_word),
    .code_out (coded)
  );

  aos_phase_latch #(.DATA_W(DATA_W)) u_lat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cap_en (phase_stb),
    .d_in   (coded),
    .q_out  (latched)
  );

  always_comb begin
    selected = ctl.bypass ? coded : latched;
    dout_oe  = !ctl.hiz;
    dout     = ctl.hiz ? '0 : selected;
  end
endmodule

// File: rtl/aos_checker.sv
module aos_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic [DATA_W-1:0] adc_word,
  input logic              phase_stb,
  input logic              ctl_bypass,
  input logic              ctl_hiz,
  input logic              ctl_gray,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe
);
  logic [DATA_W-1:0] ref_code;
  assign ref_code = ctl_gray ? (adc_word ^ (adc_word >> 1)) : adc_word;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_stb) && $past(rst_sync_n) && !ctl_bypass && !ctl_hiz)
      |-> (dout == $past(ref_code)))
    else $error("R2 capture mismatch");

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(phase_stb) && !ctl_bypass && !ctl_hiz &&
     !$past(ctl_bypass) && !$past(ctl_hiz))
      |-> $stable(dout))
    else $error("R3 hold violated");

  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bypass && !ctl_hiz) |-> (dout == ref_code))
    else $error("R4 bypass mismatch");

  p_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hiz |-> (!dout_oe && dout == '0))
    else $error("R6 disable violated");

  p_oe_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_hiz |-> dout_oe)
    else $error("R6 enable missing");
endmodule

bind adc_out_stage aos_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .adc_word   (adc_word),
  .phase_stb  (phase_stb),
  .ctl_bypass (ctl_bypass),
  .ctl_hiz    (ctl_hiz),
  .ctl_gray   (ctl_gray),
  .dout       (dout),
  .dout_oe    (dout_oe)
);

// File: tb/adc_out_stage_tb.sv
module adc_out_stage_tb;
  localparam int W = 12;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] adc_word;
  logic         phase_stb;
  logic         ctl_bypass;
  logic         ctl_hiz;
  logic         ctl_gray;
  logic [W-1:0] dout;
  logic         dout_oe;

  int checks;
  int errors;
  bit done;

  adc_out_stage #(.DATA_W(W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_word   (adc_word),
    .phase_stb  (phase_stb),
    .ctl_bypass (ctl_bypass),
    .ctl_hiz    (ctl_hiz),
    .ctl_gray   (ctl_gray),
    .dout       (dout),
    .dout_oe    (dout_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic capture(input logic [W-1:0] val);
    @(negedge clk);
    adc_word  = val;
    phase_stb = 1'b1;
    @(negedge clk);
    phase_stb = 1'b0;
  endtask

  task automatic t_reset_r1();
    check("R1 dout", dout, '0);
    check("R1 oe", {11'd0, dout_oe}, 12'd1);
  endtask

  task automatic t_latch_r2();
    capture(12'hABC);
    check("R2 binary capture", dout, 12'hABC);
  endtask

  task automatic t_hold_r3();
    @(negedge clk);
    adc_word = 12'h555;
    repeat (3) @(negedge clk);
    check("R3 hold without strobe", dout, 12'hABC);
  endtask

  task automatic t_bypass_r4();
    @(negedge clk);
    ctl_bypass = 1'b1;
    adc_word   = 12'h3C7;
    #1;
    check("R4 transparent", dout, 12'h3C7);
    adc_word = 12'h001;
    #1;
    check("R4 follows input", dout, 12'h001);
    @(negedge clk);
    ctl_bypass = 1'b0;
    #1;
    check("R4 back to latched value", dout, 12'hABC);
  endtask

  task automatic t_gray_r5();
    @(negedge clk);
    ctl_gray = 1'b1;
    capture(12'h800);
    check("R5 gray 0x800", dout, 12'hC00);
    capture(12'hFFF);
    check("R5 gray 0xFFF", dout, 12'h800);
    capture(12'h5A3);
    check("R5 gray 0x5A3", dout, to_gray(12'h5A3));
  endtask

  task automatic t_coding_order_r8();
    capture(12'h0F0);
    check("R8 gray latched", dout, 12'h088);
    @(negedge clk);
    ctl_gray = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 latched word unchanged", dout, 12'h088);
  endtask

  task automatic t_hiz_r6_r7();
    @(negedge clk);
    ctl_hiz = 1'b1;
    #1;
    check("R6 oe low", {11'd0, dout_oe}, 12'd0);
    check("R6 bus zero", dout, '0);
    capture(12'h123);
    check("R6 bus zero during capture", dout, '0);
    ctl_hiz = 1'b0;
    #1;
    check("R7 first cycle after re-enable", dout, 12'h123);
    check("R7 oe high", {11'd0, dout_oe}, 12'd1);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; adc_word = '0; phase_stb = 1'b0;
    ctl_bypass = 1'b0; ctl_hiz = 1'b0; ctl_gray = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_r1();
    t_latch_r2();
    t_hold_r3();
    t_bypass_r4();
    t_gray_r5();
    t_coding_order_r8();
    t_hiz_r6_r7();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 10000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule